// File: doc/BRIEF.md
# Saturating Sample Output Port

This block sits between a converter's decimation stage and the pins of a parallel output bus. Each wide signed result offered on its input stream is clipped to a 16-bit two's complement word. The clipped word and an out-of-range flag are loaded together into a holding register. An active-low data-ready strobe pulses for one clock to announce each new word.

The input follows valid/ready rules. A result is taken on any clock where `in_valid` and `in_ready` are both high. `in_ready` drops for exactly the one clock in which data-ready is low. A result offered during that clock is not taken, and the producer must keep it on the stream until `in_ready` returns. This guarantees that data-ready goes high again for at least one clock between two samples. The bus side is plain: the word is driven only while chip-select and read are both low. The high-impedance state is shown as a drive-enable output for the pad ring.

Top module: `sat_out_port`

## Requirements
- R1: After reset the held word is 0000h, `otr` is 0, `drdy_n` is 1, `in_ready` is 1 and `dout_oe` is 0 while `cs_n`/`rd_n` are high.
- R2: An accepted result within -32768..32767 appears unchanged (its low 16 bits) on `dout`, with `otr` 0.
- R3: An accepted result above 32767 appears on `dout` as 7FFFh, with `otr` 1.
- R4: An accepted result below -32768 appears on `dout` as 8000h, with `otr` 1.
- R5: The exact limits 32767 (7FFFh) and -32768 (8000h) count as in range and leave `otr` at 0.
- R6: After a clock edge that accepts a result, `drdy_n` is low for exactly one clock. `dout` and `otr` change only at that same edge.
- R7: `in_ready` is low exactly while `drdy_n` is low. A result offered while `in_ready` is low leaves `dout` and `otr` unchanged.
- R8: With no accepted result, `dout`, `otr` and `drdy_n` (high) keep their values indefinitely.
- R9: `dout_oe` is 1 only when `cs_n` and `rd_n` are both 0. It responds combinationally and is 0 for the other three combinations.
- R10: `otr` stays 1 across successive out-of-range samples. It returns to 0 with the first in-range sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input result valid |
| in_ready | output | 1 | Port can take a result this clock |
| in_data | input | 24 | Signed result from the decimation stage |
| cs_n | input | 1 | Active-low chip-select |
| rd_n | input | 1 | Active-low read |
| dout | output | 16 | Held two's complement word |
| dout_oe | output | 1 | Bus drive-enable (0 = high impedance) |
| drdy_n | output | 1 | Active-low data-ready strobe |
| otr | output | 1 | Out-of-range flag for the held word |

## Verification
On every clock, the assertions check four things. The strobe lasts a single clock and follows every acceptance. The held word and flag move only when the strobe is low. A raised flag always sits beside one of the two rail codes. The exact clip values, the treatment of the boundary codes, the persistence and release of the flag, and the refusal of results offered during the strobe are shown only by the bench's scenarios, which are compared against a behavioural model on every clock. The same holds for the four chip-select/read combinations.

// File: rtl/sat_out_pkg.sv
package sat_out_pkg;
  localparam int DEF_IN_W  = 24;
  localparam int DEF_OUT_W = 16;

  // Result of comparing one input against the output range
  typedef enum logic [1:0] {
    CLIP_NONE = 2'd0,
    CLIP_HIGH = 2'd1,
    CLIP_LOW  = 2'd2
  } clip_e;
endpackage

// File: rtl/sat_clip.sv
module sat_clip
  import sat_out_pkg::*;
#(
  parameter int IN_W  = DEF_IN_W,
  parameter int OUT_W = DEF_OUT_W
) (
  input  logic signed [IN_W-1:0] din,
  output logic [OUT_W-1:0]       word,
  output clip_e                  status
);
  generate
    if (IN_W > OUT_W) begin : g_clip
      localparam int EXT = IN_W - OUT_W + 1;
      localparam logic signed [IN_W-1:0] HI = {{EXT{1'b0}}, {(OUT_W-1){1'b1}}};
      localparam logic signed [IN_W-1:0] LO = {{EXT{1'b1}}, {(OUT_W-1){1'b0}}};

      always_comb begin
        if (din > HI) begin
          word   = HI[OUT_W-1:0];
          status = CLIP_HIGH;
        end else if (din < LO) begin
          word   = LO[OUT_W-1:0];
          status = CLIP_LOW;
        end else begin
          word   = din[OUT_W-1:0];
          status = CLIP_NONE;
        end
      end
    end else begin : g_pass
      // Input no wider than the output: nothing can exceed full scale
      assign word   = din[OUT_W-1:0];
      assign status = CLIP_NONE;
    end
  endgenerate
endmodule

// File: rtl/sat_hold_reg.sv
module sat_hold_reg
  import sat_out_pkg::*;
#(
  parameter int OUT_W = DEF_OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OUT_W-1:0] word,
  input  clip_e            status,
  output logic [OUT_W-1:0] word_q,
  output logic             flag_q,
  output logic             strobe_n
);
  localparam logic [OUT_W-1:0] RAIL_HI = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] RAIL_LO = {1'b1, {(OUT_W-1){1'b0}}};

  logic take;

  // Refuse input during the strobe clock so the strobe always re-arms
  assign in_ready = strobe_n;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q   <= '0;
      flag_q   <= 1'b0;
      strobe_n <= 1'b1;
    end else if (take) begin
      word_q   <= word;
      flag_q   <= (status != CLIP_NONE);
      strobe_n <= 1'b0;
    end else begin
      strobe_n <= 1'b1;
    end
  end

  // R6: strobe is a single clock wide
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |=> strobe_n);

  // R6: every accepted result produces a strobe
  p_accept_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !strobe_n);

  // R6/R8: held word and flag move only together with the strobe
  p_update_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(word_q) || !$stable(flag_q)) |-> !strobe_n);

  // R3/R4: a raised flag sits beside a rail code
  p_flag_on_rail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> (word_q == RAIL_HI || word_q == RAIL_LO));
endmodule

// File: rtl/sat_bus_gate.sv
module sat_bus_gate
  import sat_out_pkg::*;
#(
  parameter int OUT_W = DEF_OUT_W
) (
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic [OUT_W-1:0] word_q,
  output logic [OUT_W-1:0] dout,
  output logic             dout_oe
);
  // Word is always presented; the pad ring drives it only when enabled
  assign dout    = word_q;
  assign dout_oe = !cs_n && !rd_n;
endmodule

// File: rtl/sat_out_port.sv
module sat_out_port
  import sat_out_pkg::*;
#(
  parameter int IN_W  = DEF_IN_W,
  parameter int OUT_W = DEF_OUT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_data,
  input  logic                   cs_n,
  input  logic                   rd_n,
  output logic [OUT_W-1:0]       dout,
  output logic                   dout_oe,
  output logic                   drdy_n,
  output logic                   otr
);
  logic [OUT_W-1:0] clip_word;
  clip_e            clip_stat;
  logic [OUT_W-1:0] held_word;

  sat_clip #(.IN_W(IN_W), .OUT_W(OUT_W)) u_clip (
    .din    (in_data),
    .word   (clip_word),
    .status (clip_stat)
  );

  sat_hold_reg #(.OUT_W(OUT_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .word     (clip_word),
    .status   (clip_stat),
    .word_q   (held_word),
    .flag_q   (otr),
    .strobe_n (drdy_n)
  );

  sat_bus_gate #(.OUT_W(OUT_W)) u_gate (
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .word_q  (held_word),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

  // R7: back-pressure window matches the strobe
  p_ready_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> !in_ready);
endmodule

// File: tb/sat_out_port_test.sv
module sat_out_port_test;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [23:0] in_data = '0;
  logic               cs_n = 1'b1;
  logic               rd_n = 1'b1;
  logic [15:0]        dout;
  logic               dout_oe;
  logic               drdy_n;
  logic               otr;

  int n_vec = 0;
  int n_bad = 0;

  // behavioural reference state
  int m_word = 0;
  bit m_otr = 0;
  bit m_drdy = 1;

  always #2 clk = ~clk;

  sat_out_port uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cs_n(cs_n), .rd_n(rd_n), .dout(dout),
    .dout_oe(dout_oe), .drdy_n(drdy_n), .otr(otr)
  );

  function automatic int clip16(input int v, output bit flag);
    if (v > 32767) begin flag = 1; return 32767; end
    if (v < -32768) begin flag = 1; return -32768; end
    flag = 0;
    return v;
  endfunction

  task automatic compare(input string tag);
    logic [15:0] ew;
    bit eoe;
    ew  = m_word[15:0];
    eoe = (cs_n == 1'b0) && (rd_n == 1'b0);
    n_vec++;
    if (dout !== ew) begin
      n_bad++; $display("FAIL %s dout actual=%h expected=%h", tag, dout, ew);
    end
    if (otr !== m_otr) begin
      n_bad++; $display("FAIL %s otr actual=%b expected=%b", tag, otr, m_otr);
    end
    if (drdy_n !== m_drdy) begin
      n_bad++; $display("FAIL %s drdy_n actual=%b expected=%b", tag, drdy_n, m_drdy);
    end
    if (in_ready !== m_drdy) begin
      n_bad++; $display("FAIL %s in_ready actual=%b expected=%b", tag, in_ready, m_drdy);
    end
    if (dout_oe !== eoe) begin
      n_bad++; $display("FAIL %s dout_oe actual=%b expected=%b", tag, dout_oe, eoe);
    end
  endtask

  // One clock: drive at negedge, advance model at posedge, compare after
  task automatic step(input bit v, input int d, input bit cs, input bit rd, input string tag);
    bit f;
    int w;
    @(negedge clk);
    in_valid = v; in_data = d[23:0]; cs_n = cs; rd_n = rd;
    @(posedge clk);
    if (v && m_drdy) begin
      w = clip16(d, f);
      m_word = w; m_otr = f; m_drdy = 0;
    end else begin
      m_drdy = 1;
    end
    #1 compare(tag);
  endtask

  task automatic put(input int d, input string tag);
    step(1, d, 1, 1, tag);
    step(0, 0, 1, 1, tag);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");             // R1 reset state
    rst_n = 1'b1;
    step(0, 0, 1, 1, "R1");
    step(0, 0, 1, 1, "R1");

    // R2 in-range values
    put(0, "R2");
    put(1234, "R2");
    put(-5, "R2");
    put(-20000, "R2");

    // R5 exact limits
    put(32767, "R5");
    put(-32768, "R5");

    // R3 positive clip, R4 negative clip
    put(32768, "R3");
    put(8388607, "R3");
    put(-32769, "R4");
    put(-8388608, "R4");

    // R10 flag persists over out-of-range run, drops on in-range
    put(100000, "R10");
    put(-100000, "R10");
    put(40000, "R10");
    put(77, "R10");

    // R7 valid held high: every other clock accepted, others refused
    step(1, 500, 1, 1, "R7");
    step(1, 900000, 1, 1, "R7");   // refused: dout stays 01F4, otr 0
    step(1, 600, 1, 1, "R7");
    step(1, -900000, 1, 1, "R7");  // refused
    step(0, 0, 1, 1, "R7");

    // R8 hold across idle clocks while bus is read
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, "R8");

    // R9 all four chip-select/read combinations
    step(0, 0, 0, 0, "R9");
    step(0, 0, 0, 1, "R9");
    step(0, 0, 1, 0, "R9");
    step(0, 0, 1, 1, "R9");

    // R6 strobe timing with read active during update
    step(1, -31000, 0, 0, "R6");
    step(0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, "R6");

    // R1 reset again from a flagged state
    put(-70000, "R4");
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(posedge clk); m_word = 0; m_otr = 0; m_drdy = 1;
    #1 compare("R1");
    @(negedge clk); rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule